// File: doc/BRIEF.md
# Indexed Audio Codec Control Registers

This block is the host-facing control front end of an audio codec. A host reaches it through four byte-wide direct ports, selected by a two-bit address. One direct port holds an index pointer. A second port reads and writes the indirect control register that the pointer selects. A third port is the interrupt status, and the fourth is a data port that discards writes. Behind the pointer sit 32 indirect 8-bit control registers. Only the lower 16 of them can be reached until the extended-mode bit is set.

Several registers filter what a write does. The sample-format register changes only while the mode-change enable in the index pointer is set. It also changes while a playback-only change enable in the feature/status register is set, and in that case its low nibble is kept. The playback DMA engine pulses a block-complete strobe, which raises the interrupt line and a playback flag. A host write to the status port clears them again. After the mode-change enable rises, the block emulates a short calibration period by showing a busy bit on one read of the error register. The decoded control fields leave the block as registered levels.

Top module: `codec_ctrl_regfile`

## Requirements
- R1: After a synchronous reset the index port reads 0x40. Indirect registers 2-5 and 18-19 read 0x88, 6-7 read 0x80, 9 reads 0x08, 12 reads 0x8A, and 25-26 read 0xA0. Every other indirect register reads 0x00, and irq is low.
- R2: Direct address 0 is the index pointer, 1 the indirect data, 2 the status and 3 the discard data port. Index bit 7 is always stored and read as 0.
- R3: The indirect address is index bits [3:0] while bit 6 of register 12 is 0, and index bits [4:0] while it is 1. With the bit at 0, index 0x15 reaches register 5.
- R4: Register 8 (format) accepts a full write while index bit 6 (mode-change enable) is 1. While that bit is 0 and bit 4 of register 24 is 1, only bits [7:4] are written. Otherwise the write is ignored.
- R5: Writes to register 9 store bit 5 as 0.
- R6: Writes to register 11 and to registers 22, 27 and 29 are ignored. Writes to direct port 3 are discarded, and that port reads 0x00.
- R7: In register 12 only bit 6 is writable.
- R8: Any write to direct port 2 clears status bit 0, drops irq and clears bits [6:4] of register 24.
- R9: A write to register 24 that takes bit 4 from 1 to 0 clears status bit 0 and drops irq. A write that leaves bit 4 at 1 does not.
- R10: A one-cycle blk_done pulse sets status bit 0, irq and bit 4 of register 24 from the next cycle. It wins over a clear in the same cycle.
- R11: When index bit 6 rises from 0 to 1 through an index write while bits [4:3] of register 9 are nonzero, exactly one following read of register 11 returns bit 5 set. Later reads return the stored value. With those bits zero, no bit is added.
- R12: play_en is register 9 bit 0, int_en is register 10 bit 1, fmt_byte is register 8 and mode_ext is register 12 bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe (advances the calibration emulation) |
| bus_addr | input | 2 | Direct port select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| blk_done | input | 1 | Playback block-complete pulse from the DMA engine |
| irq | output | 1 | Interrupt request |
| play_en | output | 1 | Playback enable |
| int_en | output | 1 | Interrupt enable |
| fmt_byte | output | 8 | Sample rate and format byte |
| mode_ext | output | 1 | Extended-mode bit |

## Verification
Every indirect register is read back after reset and again after a write whose pattern differs from register to register. This separates plain storage from the per-register write filters and catches an index decode that aliases two registers. The format register is written under each of its three enable conditions, and each condition leaves a different value behind. The interrupt flag is set and then cleared along each of its paths: a status-port write, a feature-register write that clears the playback flag, one that keeps it set, and a status write in the same cycle as a completion pulse. Each path gives a distinct irq outcome. The calibration bit is tried with the configuration bits set and cleared, and the bench reads twice to confirm that the bit shows only once.

// File: rtl/cx_regs_pkg.sv
package cx_regs_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned IX_FMT   = 8;
  localparam int unsigned IX_CFG   = 9;
  localparam int unsigned IX_PIN   = 10;
  localparam int unsigned IX_ERR   = 11;
  localparam int unsigned IX_MODE  = 12;
  localparam int unsigned IX_RSV_A = 22;
  localparam int unsigned IX_FEAT  = 24;
  localparam int unsigned IX_RSV_B = 27;
  localparam int unsigned IX_RSV_C = 29;

  typedef enum logic [1:0] {
    PORT_INDEX  = 2'd0,
    PORT_DATA   = 2'd1,
    PORT_STATUS = 2'd2,
    PORT_PIO    = 2'd3
  } port_e;

  function automatic logic [BYTE_W-1:0] reset_value(input int unsigned idx);
    case (idx)
      2, 3, 4, 5, 18, 19: reset_value = 8'h88;
      6, 7:               reset_value = 8'h80;
      9:                  reset_value = 8'h08;
      12:                 reset_value = 8'h8A;
      25, 26:             reset_value = 8'hA0;
      default:            reset_value = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cx_index_port.sv
module cx_index_port #(
  parameter int unsigned IA_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [7:0]      wdata,
  input  logic            mode_ext,
  output logic [7:0]      idx_q,
  output logic            mce,
  output logic            mce_rise,
  output logic [IA_W-1:0] iaddr
);
  always_ff @(posedge clk) begin
    if (rst) idx_q <= 8'h40;
    else if (wr) idx_q <= wdata & 8'h7F;
  end

  assign mce      = idx_q[6];
  assign mce_rise = wr && wdata[6] && !idx_q[6];

  always_comb begin
    if (mode_ext) iaddr = idx_q[IA_W-1:0];
    else          iaddr = {1'b0, idx_q[IA_W-2:0]};
  end
endmodule

// File: rtl/cx_calib_oneshot.sv
module cx_calib_oneshot #(
  parameter int unsigned CNT_W = 2,
  parameter int unsigned LOAD  = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic consume,
  output logic active
);
  logic [CNT_W-1:0] cnt_q;

  assign active = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst)                    cnt_q <= '0;
    else if (arm)               cnt_q <= CNT_W'(LOAD);
    else if (consume && active) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/cx_ireg_bank.sv
module cx_ireg_bank
  import cx_regs_pkg::*;
#(
  parameter int unsigned NREG = 32,
  parameter int unsigned IA_W = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [IA_W-1:0] iaddr,
  input  logic [7:0]      wdata,
  input  logic            mce,
  input  logic            status_clr,
  input  logic            pb_event,
  output logic [7:0]      regs_o [NREG],
  output logic            int_o
);
  logic pmce;
  logic feat_hit;

  assign pmce     = regs_o[IX_FEAT][4];
  assign feat_hit = wr && (iaddr == IA_W'(IX_FEAT));

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] r_q;
    logic       we;
    logic [7:0] wv;

    always_comb begin
      we = wr && (iaddr == IA_W'(g));
      wv = wdata;
      if (g == IX_FMT) begin
        if (!mce) begin
          if (pmce) wv = {wdata[7:4], r_q[3:0]};
          else      we = 1'b0;
        end
      end else if (g == IX_CFG) begin
        wv[5] = 1'b0;
      end else if (g == IX_MODE) begin
        wv = {r_q[7], wdata[6], r_q[5:0]};
      end else if (g == IX_ERR || g == IX_RSV_A || g == IX_RSV_B || g == IX_RSV_C) begin
        we = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        r_q <= reset_value(g);
      end else begin
        if (we) r_q <= wv;
        if (g == IX_FEAT) begin
          if (status_clr) r_q[6:4] <= 3'b000;
          if (pb_event)   r_q[4]   <= 1'b1;
        end
      end
    end

    assign regs_o[g] = r_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                              int_o <= 1'b0;
    else if (pb_event)                    int_o <= 1'b1;
    else if (status_clr)                  int_o <= 1'b0;
    else if (feat_hit && pmce && !wdata[4]) int_o <= 1'b0;
  end
endmodule

// File: rtl/codec_ctrl_regfile.sv
module codec_ctrl_regfile
  import cx_regs_pkg::*;
#(
  parameter int unsigned IREG_CNT = 32,
  parameter int unsigned CAL_W    = 2,
  parameter int unsigned CAL_LOAD = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       blk_done,
  output logic       irq,
  output logic       play_en,
  output logic       int_en,
  output logic [7:0] fmt_byte,
  output logic       mode_ext
);
  localparam int unsigned IA_W = $clog2(IREG_CNT);

  logic [7:0]      idx_q;
  logic            mce;
  logic            mce_rise;
  logic [IA_W-1:0] iaddr;
  logic [7:0]      regs [IREG_CNT];
  logic            int_q;
  logic            cal_active;
  logic            idx_wr;
  logic            data_wr;
  logic            stat_wr;
  logic            err_rd;
  logic            cal_arm;

  assign idx_wr  = bus_wr && (bus_addr == PORT_INDEX);
  assign data_wr = bus_wr && (bus_addr == PORT_DATA);
  assign stat_wr = bus_wr && (bus_addr == PORT_STATUS);
  assign err_rd  = bus_rd && (bus_addr == PORT_DATA) && (iaddr == IA_W'(IX_ERR));
  assign cal_arm = mce_rise && (regs[IX_CFG][4:3] != 2'b00);

  cx_index_port #(.IA_W(IA_W)) idx_i (
    .clk      (clk),
    .rst      (rst),
    .wr       (idx_wr),
    .wdata    (bus_wdata),
    .mode_ext (mode_ext),
    .idx_q    (idx_q),
    .mce      (mce),
    .mce_rise (mce_rise),
    .iaddr    (iaddr)
  );

  cx_ireg_bank #(.NREG(IREG_CNT), .IA_W(IA_W)) bank_i (
    .clk        (clk),
    .rst        (rst),
    .wr         (data_wr),
    .iaddr      (iaddr),
    .wdata      (bus_wdata),
    .mce        (mce),
    .status_clr (stat_wr),
    .pb_event   (blk_done),
    .regs_o     (regs),
    .int_o      (int_q)
  );

  cx_calib_oneshot #(.CNT_W(CAL_W), .LOAD(CAL_LOAD)) cal_i (
    .clk     (clk),
    .rst     (rst),
    .arm     (cal_arm),
    .consume (err_rd),
    .active  (cal_active)
  );

  always_comb begin
    unique case (bus_addr)
      PORT_INDEX:  bus_rdata = idx_q;
      PORT_DATA: begin
        bus_rdata = regs[iaddr];
        if (iaddr == IA_W'(IX_ERR) && cal_active) bus_rdata[5] = 1'b1;
      end
      PORT_STATUS: bus_rdata = {7'd0, int_q};
      default:     bus_rdata = 8'h00;
    endcase
  end

  assign irq      = int_q;
  assign play_en  = regs[IX_CFG][0];
  assign int_en   = regs[IX_PIN][1];
  assign fmt_byte = regs[IX_FMT];
  assign mode_ext = regs[IX_MODE][6];
endmodule

// File: rtl/codec_ctrl_regfile_chk.sv
module codec_ctrl_regfile_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [1:0] bus_addr,
  input logic       rd_bit7,
  input logic       blk_done,
  input logic       irq,
  input logic [7:0] fmt_byte,
  input logic       mode_ext
);
  p_idx_bit7_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd0) |-> !rd_bit7);

  p_fmt_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == 2'd1) |=> $stable(fmt_byte));

  p_mode_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == 2'd1) |=> $stable(mode_ext));

  p_status_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd2 && !blk_done) |=> !irq);

  p_done_sets_r10: assert property (@(posedge clk) disable iff (rst)
    blk_done |=> irq);

  p_irq_cause_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(blk_done));
endmodule

bind codec_ctrl_regfile codec_ctrl_regfile_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .rd_bit7  (bus_rdata[7]),
  .blk_done (blk_done),
  .irq      (irq),
  .fmt_byte (fmt_byte),
  .mode_ext (mode_ext)
);

// File: tb/codec_ctrl_regfile_tb_top.sv
module codec_ctrl_regfile_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       blk_done = 1'b0;
  logic       irq, play_en, int_en, mode_ext;
  logic [7:0] fmt_byte;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mce_cur = 1'b1;
  logic [7:0] expv [32];
  logic [7:0] rv;

  always #5 clk = ~clk;

  codec_ctrl_regfile dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .blk_done(blk_done), .irq(irq),
    .play_en(play_en), .int_en(int_en), .fmt_byte(fmt_byte), .mode_ext(mode_ext)
  );

  function automatic logic [7:0] def_val(input int i);
    if (i inside {2, 3, 4, 5, 18, 19}) return 8'h88;
    if (i inside {6, 7}) return 8'h80;
    if (i == 9) return 8'h08;
    if (i == 12) return 8'h8A;
    if (i inside {25, 26}) return 8'hA0;
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_index(input int i);
    bus_write(2'd0, {1'b0, mce_cur, 6'(i)});
  endtask

  task automatic ireg_write(input int i, input logic [7:0] d);
    set_index(i);
    bus_write(2'd1, d);
  endtask

  task automatic ireg_read(input int i, output logic [7:0] d);
    set_index(i);
    bus_read(2'd1, d);
  endtask

  task automatic pulse_done();
    @(negedge clk);
    blk_done = 1'b1;
    @(negedge clk);
    blk_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got 00 expected 01");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_read(2'd0, rv);
    check("R1 index reset", rv, 8'h40);
    check("R1 irq reset", {7'd0, irq}, 8'h00);
    check("R1 fmt reset", fmt_byte, 8'h00);
    check("R12 play_en reset", {7'd0, play_en}, 8'h00);
    check("R12 int_en reset", {7'd0, int_en}, 8'h00);
    check("R12 mode reset", {7'd0, mode_ext}, 8'h00);
    for (int i = 0; i < 16; i++) begin
      ireg_read(i, rv);
      check($sformatf("R1 default reg %0d", i), rv, def_val(i));
    end
    // R3 index 0x12 aliases register 2 in narrow mode
    ireg_read(18, rv);
    check("R3 narrow alias", rv, def_val(2));

    // R7 only bit 6 of register 12 is writable
    ireg_write(12, 8'h40);
    ireg_read(12, rv);
    check("R7 mode set", rv, 8'hCA);
    check("R12 mode_ext", {7'd0, mode_ext}, 8'h01);
    ireg_write(12, 8'hFF);
    ireg_read(12, rv);
    check("R7 only bit6", rv, 8'hCA);
    for (int i = 16; i < 32; i++) begin
      ireg_read(i, rv);
      check($sformatf("R1 default reg %0d", i), rv, def_val(i));
    end

    // write sweep R5 R6 with per-register pattern
    for (int i = 0; i < 32; i++) expv[i] = def_val(i);
    expv[12] = 8'hCA;
    for (int i = 0; i < 32; i++) begin
      logic [7:0] p;
      p = 8'((i * 29 + 91) & 255);
      if (i == 12) continue;
      ireg_write(i, p);
      if (i == 9) expv[i] = p & 8'hDF;
      else if (!(i inside {11, 22, 27, 29})) expv[i] = p;
    end
    for (int i = 0; i < 32; i++) begin
      ireg_read(i, rv);
      check($sformatf("R5 R6 sweep reg %0d", i), rv, expv[i]);
    end
    check("R12 fmt_byte", fmt_byte, expv[8]);
    check("R12 play_en", {7'd0, play_en}, {7'd0, expv[9][0]});
    check("R12 int_en", {7'd0, int_en}, {7'd0, expv[10][1]});

    // R2 index bit7 masked, R6 discard port
    bus_write(2'd0, 8'hC5);
    bus_read(2'd0, rv);
    check("R2 bit7 masked", rv, 8'h45);
    bus_write(2'd3, 8'hFF);
    bus_read(2'd3, rv);
    check("R6 pio port", rv, 8'h00);
    bus_read(2'd2, rv);
    check("R2 status port", rv, 8'h00);

    // R3 narrow mode aliasing on write
    ireg_write(12, 8'h00);
    check("R3 mode cleared", {7'd0, mode_ext}, 8'h00);
    set_index(21);
    bus_write(2'd1, 8'h3C);
    ireg_write(12, 8'h40);
    ireg_read(5, rv);
    check("R3 alias write reg5", rv, 8'h3C);
    ireg_read(21, rv);
    check("R3 reg21 untouched", rv, expv[21]);

    // R4 format gating
    ireg_write(24, 8'h00);
    ireg_write(8, 8'hA5);
    check("R4 full write", fmt_byte, 8'hA5);
    mce_cur = 1'b0;
    set_index(8);
    bus_write(2'd1, 8'h3C);
    check("R4 locked", fmt_byte, 8'hA5);
    ireg_write(24, 8'h10);
    ireg_write(8, 8'h3C);
    check("R4 upper nibble only", fmt_byte, 8'h35);
    bus_write(2'd2, 8'h00);
    ireg_read(24, rv);
    check("R8 flags cleared", rv, 8'h00);
    ireg_write(8, 8'h77);
    check("R4 locked after clear", fmt_byte, 8'h35);

    // R10 event, R8 status clear
    ireg_write(24, 8'h63);
    pulse_done();
    check("R10 irq set", {7'd0, irq}, 8'h01);
    bus_read(2'd2, rv);
    check("R10 status int", rv, 8'h01);
    ireg_read(24, rv);
    check("R10 flag bit4", rv, 8'h73);
    bus_write(2'd2, 8'h00);
    check("R8 irq cleared", {7'd0, irq}, 8'h00);
    bus_read(2'd2, rv);
    check("R8 status cleared", rv, 8'h00);
    ireg_read(24, rv);
    check("R8 bits 6:4 cleared", rv, 8'h03);

    // R9 feature-register clear path
    pulse_done();
    ireg_write(24, 8'h13);
    check("R9 pi kept irq stays", {7'd0, irq}, 8'h01);
    bus_write(2'd1, 8'h03);
    check("R9 pi fall clears irq", {7'd0, irq}, 8'h00);

    // R10 priority over same-cycle status clear
    @(negedge clk);
    bus_addr = 2'd2; bus_wr = 1'b1; blk_done = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; blk_done = 1'b0;
    check("R10 event wins", {7'd0, irq}, 8'h01);
    bus_write(2'd2, 8'h00);
    check("R8 clear after", {7'd0, irq}, 8'h00);

    // R11 calibration emulation
    ireg_write(9, 8'h18);
    bus_write(2'd0, 8'h4B);
    mce_cur = 1'b1;
    bus_read(2'd1, rv);
    check("R11 busy once", rv, 8'h20);
    bus_read(2'd1, rv);
    check("R11 busy gone", rv, 8'h00);
    mce_cur = 1'b0;
    ireg_write(9, 8'h00);
    bus_write(2'd0, 8'h4B);
    mce_cur = 1'b1;
    bus_read(2'd1, rv);
    check("R11 no arm without cfg", rv, 8'h00);

    // R12 decoded levels
    ireg_write(9, 8'h01);
    check("R12 play_en on", {7'd0, play_en}, 8'h01);
    ireg_write(10, 8'h02);
    check("R12 int_en on", {7'd0, int_en}, 8'h01);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule